// File: doc/BRIEF.md
# Timer Counter Channel

A single programmable timer channel built around a parameterised counter (16 bits by default). The counter advances one step on each cycle where the count-enable input is high and the channel is not halted. It counts up or down. In free-running mode it wraps across the full range. In period mode it wraps against a programmable period value. Each wrap raises a sticky interrupt status bit, and three compare values can raise their own status bits when the counter lands on them.

A waveform pin is driven from counter events. A hit on the first compare value moves the pin to its active level. The next wrap returns it to its idle level. The idle level is chosen by a polarity control bit, and the pin can be gated off entirely.

Software reaches the channel through a plain register port: a write strobe, a read strobe, a 3-bit address and a data word. Reads return data one cycle after the strobe. The control word holds a self-clearing restart bit that zeroes the count. The interrupt output is the OR of the status bits that software has enabled. Reading the status register clears it.

Top module: `tmr_chan`

## Requirements
- R1: After reset the control register reads 0x21 (halted, waveform gated off), the count, period, compare values, enable mask and status all read 0, and both `irq` and `wave` are low.
- R2: While control bit 0 (halt) is 1, or while `cnt_en` is low, the count keeps its value.
- R3: With control bit 1 at 0 (free-running), the counter wraps from all-ones to 0 when counting up and from 0 to all-ones when counting down. Each wrap sets status bit 4.
- R4: With control bit 1 at 1 (period mode), counting up moves from the period value (or any value above it) to 0, and counting down moves from 0 to the period value. Each such wrap sets status bit 0.
- R5: Control bit 2 selects the direction: 0 adds one per step and 1 subtracts one per step, away from the wrap points.
- R6: With control bit 3 at 1, a step that lands the count on compare value k (k = 1..3) sets status bit k. With bit 3 at 0, no compare status bit is ever set.
- R7: `irq` is high exactly when some status bit and the same bit of the enable mask are both 1.
- R8: Status bits stay set until a read of address 6. That read returns the bits and clears them.
- R9: Writing control bit 4 as 1 zeroes the count one cycle later and clears the bit in the same cycle. A control read afterwards shows bit 4 as 0. The halt bit is not touched.
- R10: `wave` is 0 while control bit 5 is 1. Otherwise it shows an active flag XOR control bit 6. The active flag is set by a compare-1 hit (bit 3 set), and cleared by any wrap or restart. A wrap wins over a hit in the same step.
- R11: Address map: 0 control (bits 6:0), 1 period, 2/3/4 compare values 1/2/3, 5 enable mask (bits 4:0), 6 status, 7 count. Writes to addresses 6 and 7 have no effect. `rdata` is valid on the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable; one step per high cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data, registered |
| irq | output | 1 | OR of enabled status bits |
| wave | output | 1 | Waveform pin |

## Verification
A wrong count shows up on the first readback of address 7 after the step that produced it. The bench reads the count after every step of its sweeps, so a wrong next-value or a wrong wrap point is caught within one step. A missing or spurious event is visible at once: `irq` and `wave` follow the status and active flag without delay, and the status read after each step shows any extra or missing bit. A restart bit that fails to clear would keep the count at zero, so the following step would expose it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NMATCH  = 3;
  localparam int ST_W    = NMATCH + 2;
  localparam int CTRL_W  = 7;
  localparam int ADDR_W  = 3;
  localparam int ST_INTV = 0;
  localparam int ST_MAT0 = 1;
  localparam int ST_OVF  = NMATCH + 1;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_INTV = 3'd1,
    A_MAT1 = 3'd2,
    A_MAT2 = 3'd3,
    A_MAT3 = 3'd4,
    A_IEN  = 3'd5,
    A_STAT = 3'd6,
    A_CNT  = 3'd7
  } reg_addr_e;

  // bit 6 down to bit 0
  typedef struct packed {
    logic pol;
    logic wave_off;
    logic restart;
    logic match_on;
    logic down;
    logic intv_mode;
    logic halt;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{pol: 1'b0, wave_off: 1'b1, restart: 1'b0,
                                 match_on: 1'b0, down: 1'b0, intv_mode: 1'b0,
                                 halt: 1'b1};
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [CNT_W-1:0]            wdata,
  input  logic [CNT_W-1:0]            cnt,
  input  logic [ST_W-1:0]             evt,
  output ctrl_t                       ctrl,
  output logic [CNT_W-1:0]            intv,
  output logic [NMATCH-1:0][CNT_W-1:0] mat,
  output logic [ST_W-1:0]             ien,
  output logic [ST_W-1:0]             status,
  output logic [CNT_W-1:0]            rdata
);
  reg_addr_e        a;
  logic             rd_stat;
  logic [CNT_W-1:0] rd_mux;

  assign a       = reg_addr_e'(addr);
  assign rd_stat = rd_en && (a == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= CTRL_RST;
      intv   <= '0;
      ien    <= '0;
      status <= '0;
      rdata  <= '0;
    end else begin
      if (wr_en && a == A_CTRL)
        ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
      else if (ctrl.restart)
        ctrl.restart <= 1'b0;
      if (wr_en && a == A_INTV) intv <= wdata;
      if (wr_en && a == A_IEN)  ien  <= wdata[ST_W-1:0];
      status <= (rd_stat ? '0 : status) | evt;
      if (rd_en) rdata <= rd_mux;
    end
  end

  for (genvar g = 0; g < NMATCH; g++) begin : g_mat
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(A_MAT1) + g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mat[g] <= '0;
      else if (wr_en && addr == MY_ADDR) mat[g] <= wdata;
    end
  end

  always_comb begin
    case (a)
      A_CTRL:  rd_mux = {{(CNT_W-CTRL_W){1'b0}}, ctrl};
      A_INTV:  rd_mux = intv;
      A_MAT1:  rd_mux = mat[0];
      A_MAT2:  rd_mux = mat[1];
      A_MAT3:  rd_mux = mat[2];
      A_IEN:   rd_mux = {{(CNT_W-ST_W){1'b0}}, ien};
      A_STAT:  rd_mux = {{(CNT_W-ST_W){1'b0}}, status};
      A_CNT:   rd_mux = cnt;
      default: rd_mux = '0;
    endcase
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             restart,
  input  logic             down,
  input  logic             intv_mode,
  input  logic [CNT_W-1:0] intv,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] nxt,
  output logic             moved,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] TOP = '1;
  logic wrap;

  always_comb begin
    wrap = 1'b0;
    if (down) begin
      if (cnt == '0) begin
        wrap = 1'b1;
        nxt  = intv_mode ? intv : TOP;
      end else begin
        nxt = cnt - 1'b1;
      end
    end else begin
      if (intv_mode ? (cnt >= intv) : (cnt == TOP)) begin
        wrap = 1'b1;
        nxt  = '0;
      end else begin
        nxt = cnt + 1'b1;
      end
    end
  end

  assign moved    = step && !restart;
  assign wrap_evt = moved && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (step)    cnt <= nxt;
  end
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int CNT_W  = 16,
  parameter int NMATCH = 3
) (
  input  logic                         moved,
  input  logic                         match_on,
  input  logic [CNT_W-1:0]             nxt,
  input  logic [NMATCH-1:0][CNT_W-1:0] mat,
  output logic [NMATCH-1:0]            hit
);
  for (genvar g = 0; g < NMATCH; g++) begin : g_cmp
    assign hit[g] = moved && match_on && (nxt == mat[g]);
  end
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic set_act,
  input  logic clr_act,
  input  logic wave_off,
  input  logic pol,
  output logic wave
);
  logic act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  act <= 1'b0;
    else if (restart || clr_act) act <= 1'b0;
    else if (set_act)            act <= 1'b1;
  end

  assign wave = !wave_off && (act ^ pol);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq,
  output logic             wave
);
  ctrl_t                        ctrl_q;
  logic [CNT_W-1:0]             intv_q;
  logic [NMATCH-1:0][CNT_W-1:0] mat_q;
  logic [ST_W-1:0]              ien_q;
  logic [ST_W-1:0]              status_q;
  logic [ST_W-1:0]              evt;
  logic [CNT_W-1:0]             cnt_q;
  logic [CNT_W-1:0]             cnt_nxt;
  logic                         moved;
  logic                         wrap_evt;
  logic [NMATCH-1:0]            hit;
  logic                         step;

  assign step = cnt_en && !ctrl_q.halt;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt(cnt_q), .evt(evt), .ctrl(ctrl_q), .intv(intv_q),
    .mat(mat_q), .ien(ien_q), .status(status_q), .rdata(rdata)
  );

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .step(step), .restart(ctrl_q.restart),
    .down(ctrl_q.down), .intv_mode(ctrl_q.intv_mode), .intv(intv_q),
    .cnt(cnt_q), .nxt(cnt_nxt), .moved(moved), .wrap_evt(wrap_evt)
  );

  tmr_match #(.CNT_W(CNT_W), .NMATCH(NMATCH)) u_match (
    .moved(moved), .match_on(ctrl_q.match_on), .nxt(cnt_nxt), .mat(mat_q),
    .hit(hit)
  );

  tmr_wave u_wave (
    .clk(clk), .rst_n(rst_n), .restart(ctrl_q.restart), .set_act(hit[0]),
    .clr_act(wrap_evt), .wave_off(ctrl_q.wave_off), .pol(ctrl_q.pol),
    .wave(wave)
  );

  always_comb begin
    evt                          = '0;
    evt[ST_INTV]                 = wrap_evt && ctrl_q.intv_mode;
    evt[ST_OVF]                  = wrap_evt && !ctrl_q.intv_mode;
    evt[ST_MAT0 +: NMATCH]       = hit;
  end

  assign irq = |(status_q & ien_q);
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             wr_en,
  input logic             rd_en,
  input logic [2:0]       addr,
  input ctrl_t            ctrl,
  input logic [CNT_W-1:0] cnt,
  input logic [ST_W-1:0]  status
);
  logic adv;
  assign adv = cnt_en && !ctrl.halt && !ctrl.restart;

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.halt && !ctrl.restart) |=> $stable(cnt));  // R2

  AST_UP_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ctrl.down && !ctrl.intv_mode && cnt != '1) |=> (cnt == $past(cnt) + 1'b1));  // R5

  AST_DOWN_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ctrl.down && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));  // R5

  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ctrl.down && !ctrl.intv_mode && cnt == '1) |=> (cnt == '0 && status[ST_OVF]));  // R3

  AST_RESTART_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.restart && !(wr_en && addr == A_CTRL)) |=> (!ctrl.restart && cnt == '0));  // R9

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && addr == A_STAT) |=> ((status & $past(status)) == $past(status)));  // R8
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .ctrl(ctrl_q), .cnt(cnt_q), .status(status_q)
);

// File: tb/tmr_chan_bench.sv
module tmr_chan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int TOPV = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [CNT_W-1:0] wdata = '0, rdata;
  logic irq, wave;

  tmr_chan #(.CNT_W(CNT_W)) u_tmr_chan (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .wave(wave)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  // model state
  int m_cnt = 0, m_stat = 0, m_ien = 0, m_intv_val = 0;
  int m_mat[3] = '{0, 0, 0};
  bit m_act = 0, m_halt = 1, m_intv = 0, m_down = 0, m_match = 0;
  bit m_wave_off = 1, m_pol = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; addr = 3'(a); wdata = CNT_W'(d);
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
    case (a)
      0: begin
        m_halt = d[0]; m_intv = d[1]; m_down = d[2]; m_match = d[3];
        m_wave_off = d[5]; m_pol = d[6];
        if (d[4]) begin m_cnt = 0; m_act = 0; end
      end
      1: m_intv_val = d;
      2, 3, 4: m_mat[a-2] = d;
      5: m_ien = d & 5'h1f;
      default: ;
    endcase
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); rd_en = 1'b1; addr = 3'(a);
    @(negedge clk); rd_en = 1'b0;
    v = int'(rdata);
    if (a == 6) m_stat = 0;
  endtask

  task automatic step();
    bit wrap = 0;
    @(negedge clk); cnt_en = 1'b1;
    @(negedge clk); cnt_en = 1'b0;
    if (m_halt) return;
    if (m_down) begin
      if (m_cnt == 0) begin wrap = 1; m_cnt = m_intv ? m_intv_val : TOPV; end
      else m_cnt--;
    end else begin
      if (m_intv ? (m_cnt >= m_intv_val) : (m_cnt == TOPV)) begin wrap = 1; m_cnt = 0; end
      else m_cnt++;
    end
    if (wrap) m_stat |= m_intv ? 1 : 16;
    for (int i = 0; i < 3; i++)
      if (m_match && m_cnt == m_mat[i]) m_stat |= (1 << (i + 1));
    if (m_match && m_cnt == m_mat[0]) m_act = 1;
    if (wrap) m_act = 0;
  endtask

  // check pins, then count, then status (read clears)
  task automatic chk_all(string req);
    int v;
    chk({req, " wave"}, int'(wave), m_wave_off ? 0 : int'(m_act ^ m_pol));
    chk({req, " irq"}, int'(irq), int'((m_stat & m_ien) != 0));
    rd(7, v); chk({req, " count"}, v, m_cnt);
    begin
      int e = m_stat;
      rd(6, v); chk({req, " status"}, v, e);
    end
  endtask

  task automatic sweep(string req, int n);
    for (int i = 0; i < n; i++) begin step(); chk_all(req); end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all-reqs actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 'h21);
    chk("R1 wave", int'(wave), 0);
    chk("R1 irq", int'(irq), 0);
    for (int a = 1; a < 8; a++) begin rd(a, v); chk("R1 reg", v, 0); end

    // R11 address map and ignored writes
    wr(1, 4); wr(2, 2); wr(3, 3); wr(4, 7); wr(5, 'h3f);
    rd(1, v); chk("R11 period", v, 4);
    rd(2, v); chk("R11 cmp1", v, 2);
    rd(3, v); chk("R11 cmp2", v, 3);
    rd(4, v); chk("R11 cmp3", v, 7);
    rd(5, v); chk("R11 ien", v, 'h1f);
    wr(7, 'h1234); rd(7, v); chk("R11 count write ignored", v, 0);
    wr(6, 'h1f);   rd(6, v); chk("R11 status write ignored", v, 0);
    wr(5, 0);

    // R2 halted: steps have no effect
    sweep("R2", 3);
    wr(0, 'h20);
    repeat (3) @(negedge clk);
    rd(7, v); chk("R2 cnt_en low", v, 0);
    sweep("R5 up", 5);

    // R4 period mode, match off (R6 negative: count passes 2,3)
    wr(0, 'h32);
    rd(0, v); chk("R9 restart bit reads 0", v, 'h22);
    rd(7, v); chk("R9 count zero", v, 0);
    sweep("R4 up", 12);
    wr(0, 'h36);
    sweep("R4 down", 12);

    // R3 free-running wraps
    wr(0, 'h34);
    sweep("R3 down wrap", 2);
    wr(0, 'h20);
    sweep("R3 up wrap", 3);

    // R6 / R7 compare hits and mask
    wr(1, 9); wr(5, 'h04); wr(0, 'h3a);
    sweep("R6", 22);
    wr(5, 'h1f);
    sweep("R7", 12);
    wr(5, 'h0a);
    sweep("R7 mask", 12);

    // R8 sticky status across idle cycles
    wr(5, 'h01); wr(0, 'h32);
    for (int i = 0; i < 12; i++) step();
    repeat (4) @(negedge clk);
    chk("R8 irq held", int'(irq), 1);
    rd(6, v); chk("R8 first read", v, 1);
    rd(6, v); chk("R8 second read", v, 0);
    chk("R8 irq cleared", int'(irq), 0);
    rd(7, v); chk("R8 count", v, m_cnt);

    // R10 waveform
    wr(1, 4); wr(2, 2); wr(5, 0);
    wr(0, 'h5a);
    chk("R10 idle high", int'(wave), 1);
    sweep("R10 pol1", 11);
    wr(0, 'h1a);
    chk("R10 idle low", int'(wave), 0);
    sweep("R10 pol0", 11);
    wr(2, 0); wr(0, 'h1a);
    sweep("R10 wrap wins", 11);
    wr(2, 2); wr(0, 'h3a);
    sweep("R10 gated", 8);
    wr(0, 'h1e);
    sweep("R10 down", 11);

    finish_run();
  end
endmodule